// File: doc/BRIEF.md
# Multiphase PWM Phase Sequencer

The sequencer produces up to four logic-level PWM phase outputs. All of them are timed from one master-clock slot, which is `SLOT` cycles of `clk`. After `en` is taken high, the block holds every output low for a detection window of two master slots. In the last cycle of that window it reads two strap inputs. These tell it whether the upper phase outputs are tied low on the board, and from them it decides whether 2, 3 or 4 phases are in use.

Once the phase count is fixed, the active phases are rotated one master slot apart, in phase order. Each phase therefore repeats every `N*SLOT` cycles, where N is the active-phase count. Every phase takes its own duty command, counted in `clk` cycles from the start of its period. A phase samples its command once, on the first cycle of each of its own periods. The command may reach the full period, and any number of phases may be high at once.

Deasserting `en` clears the outputs and the phase count. The next enable runs detection again.

Top module: `mpwm_sequencer`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls with `en` low, `pwm_out` is 0 and `phase_count` is 0.
- R2: `en` sampled high in the idle state starts a detection window of 2*SLOT cycles. During the window `pwm_out` is 0 and `phase_count` is 0. The count appears in the cycle after the window ends.
- R3: The straps are sampled only in the last cycle of the window. The decode is: `strap4_low`=0 gives 4 phases; `strap4_low`=1 with `strap3_low`=0 gives 3; both at 1 give 2. `phase_count` then holds this value unchanged while `en` stays high, whatever the straps do afterwards.
- R4: A phase whose index is at or above the phase count is never driven high. With 3 phases, bit 3 stays 0; with 2 phases, bits 3:2 stay 0.
- R5: Bit k of `pwm_out` (k = 0..3) is phase k+1. Its first period starts k*SLOT cycles after the first run cycle, and it then repeats every N*SLOT cycles.
- R6: A phase is high for exactly its duty command's number of cycles at the start of each of its periods. The command is field k, `duty_cmd[k*DW +: DW]`, sampled on the first cycle of that phase's period. A change at any other time takes effect only from the next period.
- R7: A duty command of 0 keeps the phase low for the whole period. A command equal to or above N*SLOT keeps it high for the whole period, with no low cycle between periods.
- R8: Phases are independent, so when duty commands exceed SLOT, more than one output is high in the same cycle.
- R9: `en` sampled low clears `pwm_out` and `phase_count` in the next cycle. A later enable repeats detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one master slot is SLOT cycles |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables detection and then phase rotation |
| strap3_low | input | 1 | High when phase 3 output is strapped to ground |
| strap4_low | input | 1 | High when phase 4 output is strapped to ground |
| duty_cmd | input | 4*DW | Per-phase duty command in clk cycles, phase k in bits k*DW +: DW |
| pwm_out | output | 4 | Phase outputs, bit k is phase k+1 |
| phase_count | output | 3 | Active phase count (2, 3 or 4); 0 while idle or detecting |

## Verification
Every output is registered. A change on `en`, the straps or a duty command therefore shows one clock edge after the rising edge that samples it. The exceptions are the phase count, which shows 2*SLOT+1 edges after `en` is first seen high, and duty changes, which wait for the first cycle of the phase's next period.

The bench drives inputs on falling edges. Its behavioural model steps on the same rising edge as the design, and outputs are compared on the following falling edge. Directed checks count the falling edges after a stimulus to land on the exact cycle where the result is due, and pulse widths are measured over whole periods in steady state.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

    localparam int MAX_PHASES = 4;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_DETECT = 2'd1,
        SQ_RUN    = 2'd2
    } seq_st_e;

    // Control word handed from the sequencing FSM to the timing datapath,
    // describing the state that the next clock edge will establish.
    typedef struct packed {
        logic       run_nxt;
        logic       start;
        logic [2:0] nph_nxt;
    } seq_ctl_t;

    // Strap decode: upper phase grounded removes it from rotation.
    function automatic logic [2:0] decode_count(input logic gnd3, input logic gnd4);
        if (!gnd4)
            return 3'd4;
        else if (!gnd3)
            return 3'd3;
        else
            return 3'd2;
    endfunction

endpackage

// File: rtl/mpwm_phase_detect.sv
module mpwm_phase_detect
    import mpwm_pkg::*;
#(
    parameter int SLOT = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     gnd3,
    input  logic     gnd4,
    output seq_ctl_t ctl,
    output logic [2:0] nph_q
);

    localparam int DET_LEN = 2 * SLOT;
    localparam int DCW     = $clog2(DET_LEN);

    seq_st_e        st_q, st_n;
    logic [DCW-1:0] cnt_q, cnt_n;
    logic [2:0]     nph_n;

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        nph_n = nph_q;
        unique case (st_q)
            SQ_IDLE: begin
                nph_n = 3'd0;
                cnt_n = '0;
                if (en) st_n = SQ_DETECT;
            end
            SQ_DETECT: begin
                if (!en) begin
                    st_n  = SQ_IDLE;
                    cnt_n = '0;
                end else if (cnt_q == DCW'(DET_LEN - 1)) begin
                    st_n  = SQ_RUN;
                    cnt_n = '0;
                    nph_n = decode_count(gnd3, gnd4);
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            SQ_RUN: begin
                if (!en) begin
                    st_n  = SQ_IDLE;
                    nph_n = 3'd0;
                end
            end
            default: begin
                st_n  = SQ_IDLE;
                cnt_n = '0;
                nph_n = 3'd0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_IDLE;
            cnt_q <= '0;
            nph_q <= 3'd0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            nph_q <= nph_n;
        end
    end

    always_comb begin
        ctl.run_nxt = !rst && (st_n == SQ_RUN);
        ctl.start   = !rst && (st_n == SQ_RUN) && (st_q != SQ_RUN);
        ctl.nph_nxt = nph_n;
    end

endmodule

// File: rtl/mpwm_slot_timer.sv
module mpwm_slot_timer
    import mpwm_pkg::*;
#(
    parameter int SLOT = 8,
    parameter int PW   = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_ctl_t      ctl,
    output logic [PW-1:0] pos_nxt,
    output logic [PW-1:0] per_nxt
);

    logic [PW-1:0] pos_q;

    always_comb begin
        per_nxt = PW'(SLOT) * PW'(ctl.nph_nxt);
        if (!ctl.run_nxt || ctl.start)
            pos_nxt = '0;
        else if (pos_q == per_nxt - 1'b1)
            pos_nxt = '0;
        else
            pos_nxt = pos_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pos_q <= '0;
        else     pos_q <= pos_nxt;
    end

endmodule

// File: rtl/mpwm_phase_channel.sv
module mpwm_phase_channel #(
    parameter int IDX  = 0,
    parameter int SLOT = 8,
    parameter int PW   = 6,
    parameter int DW   = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          act,
    input  logic [PW-1:0] pos_nxt,
    input  logic [PW-1:0] per_nxt,
    input  logic [DW-1:0] duty,
    output logic          pwm
);

    localparam int          CW  = ((DW > PW) ? DW : PW) + 1;
    localparam logic [PW-1:0] OFF = PW'(IDX * SLOT);

    logic [PW-1:0] t_v;
    logic [PW-1:0] sat_v;
    logic [PW-1:0] lat_q;

    always_comb begin
        if (pos_nxt >= OFF)
            t_v = pos_nxt - OFF;
        else
            t_v = pos_nxt + per_nxt - OFF;
        if (CW'(duty) >= CW'(per_nxt))
            sat_v = per_nxt;
        else
            sat_v = PW'(duty);
    end

    always_ff @(posedge clk) begin
        if (rst || !act) begin
            lat_q <= '0;
            pwm   <= 1'b0;
        end else if (t_v == '0) begin
            lat_q <= sat_v;
            pwm   <= (sat_v != '0);
        end else begin
            pwm   <= (t_v < lat_q);
        end
    end

endmodule

// File: rtl/mpwm_sequencer.sv
module mpwm_sequencer
    import mpwm_pkg::*;
#(
    parameter int SLOT = 8,
    parameter int DW   = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic                       strap3_low,
    input  logic                       strap4_low,
    input  logic [MAX_PHASES*DW-1:0]   duty_cmd,
    output logic [MAX_PHASES-1:0]      pwm_out,
    output logic [2:0]                 phase_count
);

    localparam int PW = $clog2(MAX_PHASES * SLOT + 1);

    seq_ctl_t      ctl;
    logic [PW-1:0] pos_nxt;
    logic [PW-1:0] per_nxt;

    mpwm_phase_detect #(.SLOT(SLOT)) u_detect (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .gnd3  (strap3_low),
        .gnd4  (strap4_low),
        .ctl   (ctl),
        .nph_q (phase_count)
    );

    mpwm_slot_timer #(.SLOT(SLOT), .PW(PW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .pos_nxt (pos_nxt),
        .per_nxt (per_nxt)
    );

    for (genvar k = 0; k < MAX_PHASES; k++) begin : g_ph
        logic act_k;
        assign act_k = ctl.run_nxt && (ctl.nph_nxt > 3'(k));

        mpwm_phase_channel #(
            .IDX  (k),
            .SLOT (SLOT),
            .PW   (PW),
            .DW   (DW)
        ) u_ch (
            .clk     (clk),
            .rst     (rst),
            .act     (act_k),
            .pos_nxt (pos_nxt),
            .per_nxt (per_nxt),
            .duty    (duty_cmd[k*DW +: DW]),
            .pwm     (pwm_out[k])
        );
    end

endmodule

// File: rtl/mpwm_sequencer_chk.sv
module mpwm_sequencer_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic [3:0] pwm_out,
    input logic [2:0] phase_count
);

    // R9: disabling clears everything on the next edge
    p_quiet_off_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pwm_out == 4'b0 && phase_count == 3'd0));

    // R2: no output while the count is not yet known
    p_window_low_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_count == 3'd0) |-> (pwm_out == 4'b0));

    // R2: a fresh enable always restarts detection
    p_rearm_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |=> (phase_count == 3'd0));

    // R3: only legal counts appear
    p_count_legal_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_count == 3'd0) || (phase_count == 3'd2) ||
        (phase_count == 3'd3) || (phase_count == 3'd4));

    // R3: count frozen while enabled
    p_count_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_count != 3'd0 && en) |=> (phase_count == $past(phase_count)));

    // R4: removed phases stay low
    p_three_ph_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_count == 3'd3) |-> !pwm_out[3]);

    p_two_ph_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_count == 3'd2) |-> (pwm_out[3:2] == 2'b00));

endmodule

bind mpwm_sequencer mpwm_sequencer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .pwm_out     (pwm_out),
    .phase_count (phase_count)
);

// File: tb/tb_mpwm_sequencer.sv
module tb_mpwm_sequencer;

    localparam int SLOT = 8;
    localparam int DW   = 6;
    localparam int DET  = 2 * SLOT;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            en  = 1'b0;
    logic            strap3_low = 1'b0;
    logic            strap4_low = 1'b0;
    logic [4*DW-1:0] duty_cmd = '0;
    logic [3:0]      pwm_out;
    logic [2:0]      phase_count;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;   // 250 MHz

    mpwm_sequencer #(.SLOT(SLOT), .DW(DW)) dut (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .strap3_low  (strap3_low),
        .strap4_low  (strap4_low),
        .duty_cmd    (duty_cmd),
        .pwm_out     (pwm_out),
        .phase_count (phase_count)
    );

    // ---------------- behavioural reference ----------------
    int   m_mode = 0;      // 0 off, 1 window, 2 running
    int   m_age  = 0;
    int   m_run  = 0;
    int   m_n    = 0;
    int   m_lat [4];
    logic [3:0] exp_pwm = '0;
    int   exp_n = 0;

    function automatic int strap_count(input logic s3, input logic s4);
        if (!s4) return 4;
        if (!s3) return 3;
        return 2;
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst || !en) begin
            m_mode = 0; m_age = 0; m_run = 0; m_n = 0;
            for (int k = 0; k < 4; k++) m_lat[k] = 0;
            exp_pwm = '0; exp_n = 0;
        end else if (m_mode == 0) begin
            m_mode = 1; m_age = 0;
        end else if (m_mode == 1 && m_age < DET - 1) begin
            m_age++;
        end else begin
            if (m_mode == 1) begin
                m_mode = 2; m_run = 0;
                m_n = strap_count(strap3_low, strap4_low);
            end else begin
                m_run++;
            end
            exp_n = m_n;
            for (int k = 0; k < 4; k++) begin
                int per, t, tm, d;
                per = m_n * SLOT;
                t = m_run - k * SLOT;
                exp_pwm[k] = 1'b0;
                if (k < m_n && t >= 0) begin
                    tm = t % per;
                    if (tm == 0) begin
                        d = int'(duty_cmd[k*DW +: DW]);
                        m_lat[k] = (d >= per) ? per : d;
                    end
                    exp_pwm[k] = (m_lat[k] > tm);
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    int ov_cnt = 0;
    logic [3:0] ever_high = '0;
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (pwm_out !== exp_pwm || int'(phase_count) != exp_n) begin
                errors++;
                $display("FAIL %s cycle %0d: pwm=%b cnt=%0d expected pwm=%b cnt=%0d",
                         cur_req, cycles, pwm_out, phase_count, exp_pwm, exp_n);
            end
            if ($countones(pwm_out) > 1) ov_cnt++;
            ever_high |= pwm_out;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++; checks++;
            $display("FAIL watchdog (all reqs): cycles=%0d expected below 200000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input int act, input int expv, input string what);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_duty(input int d0, input int d1, input int d2, input int d3);
        duty_cmd = {DW'(d3), DW'(d2), DW'(d1), DW'(d0)};
    endtask

    task automatic ones(input int b, input int len, output int cnt);
        cnt = 0;
        repeat (len) begin
            @(negedge clk);
            cnt += int'(pwm_out[b]);
        end
    endtask

    task automatic enable_and_detect(input int expn);
        en = 1'b1;
        ticks(DET);
        check("R2", int'(phase_count), 0, "count at end of window");
        check("R2", int'(pwm_out), 0, "outputs at end of window");
        ticks(1);
        check("R3", int'(phase_count), expn, "detected phase count");
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int c;
        ticks(3);
        check("R1", int'(pwm_out), 0, "pwm under reset");
        check("R1", int'(phase_count), 0, "count under reset");
        rst = 1'b0;
        ticks(1);
        check("R1", int'(pwm_out), 0, "pwm after reset");
        check("R1", int'(phase_count), 0, "count after reset");

        // four phases, distinct duties
        cur_req = "R5";
        set_duty(3, 5, 12, 31);
        enable_and_detect(4);
        ticks(4 * 32);
        ones(2, 32, c); check("R6", c, 12, "phase3 width over one period");
        ones(3, 32, c); check("R7", c, 31, "phase4 near-full width");

        // duty change mid-period only lands at the next period
        cur_req = "R6";
        ticks(5);
        set_duty(20, 5, 12, 31);
        ticks(64);
        ones(0, 32, c); check("R6", c, 20, "phase1 width after update");

        // zero and saturated duty
        cur_req = "R7";
        set_duty(50, 0, 12, 31);
        ticks(64);
        ones(0, 32, c); check("R7", c, 32, "saturated phase1 high all period");
        ones(1, 32, c); check("R7", c, 0, "zero duty phase2 low all period");

        // overlap
        cur_req = "R8";
        set_duty(20, 20, 20, 20);
        ticks(64);
        ov_cnt = 0;
        ticks(32);
        check("R8", (ov_cnt > 0) ? 1 : 0, 1, "cycles with several phases high");

        // disable
        cur_req = "R9";
        en = 1'b0;
        ticks(1);
        check("R9", int'(pwm_out), 0, "pwm after disable");
        check("R9", int'(phase_count), 0, "count after disable");
        ticks(3);

        // three phases
        cur_req = "R4";
        strap4_low = 1'b1;
        set_duty(30, 30, 30, 30);
        enable_and_detect(3);
        ever_high = '0;
        strap4_low = 1'b0;    // late strap change is ignored
        ticks(96);
        check("R4", int'(ever_high[3]), 0, "phase4 ever high with 3 phases");
        check("R3", int'(phase_count), 3, "count unchanged after strap change");
        ones(0, 24, c); check("R7", c, 24, "phase1 saturated at 3-phase period");
        en = 1'b0; ticks(2);

        // two phases
        strap3_low = 1'b1; strap4_low = 1'b1;
        set_duty(10, 14, 20, 20);
        enable_and_detect(2);
        ever_high = '0;
        ticks(48);
        check("R4", int'(ever_high[3:2]), 0, "phases 3/4 ever high with 2 phases");
        ones(0, 16, c); check("R6", c, 10, "phase1 width at 2-phase period");
        ones(1, 16, c); check("R6", c, 14, "phase2 width at 2-phase period");
        en = 1'b0; ticks(2);

        // only phase 3 strapped: still four phases
        cur_req = "R3";
        strap3_low = 1'b1; strap4_low = 1'b0;
        set_duty(4, 4, 4, 4);
        enable_and_detect(4);
        ticks(40);
        en = 1'b0; ticks(2);

        // strap read only in the last window cycle
        strap3_low = 1'b0; strap4_low = 1'b1;
        en = 1'b1;
        ticks(DET);
        strap4_low = 1'b0;
        ticks(1);
        check("R3", int'(phase_count), 4, "strap sampled at window end");
        ticks(40);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule